// File: doc/BRIEF.md
# Suspend and Wake Sequencer

This block moves a device into a low-activity sleep state and back out again, always in the same order. A request input asks for sleep. While the device is awake, a status flag is high. When the request rises, the block first locks every clocked storage element against writes and drops the status flag. It then freezes the device pins at their configured sleep behaviour. Last, it cuts off the inputs and the interconnect. An optional glitch filter can delay all of these actions until the request has stayed high for a whole window. A pulse that is too short then has no effect.

When the request falls, a wake-up delay runs first. At its end the status flag rises and inputs are enabled again in the same cycle. From that cycle, the write lock and the pin freeze are each released after their own cycle count, which is set at the block's pins. If the request rises again while the block is waking up, the exit is dropped and entry restarts at the write lock. The fixed delays are parameters given in clock cycles. The request passes through a two-flop synchronizer.

Top module: `slumber_seq`

## Requirements
- R1: After reset, `awake_o` is 1 and `wprot_o`, `ohold_o` and `indis_o` are 0.
- R2: With `filt_en_i` low, `awake_o` falls and `wprot_o` rises in the same cycle, 3 clock edges after the edge that first samples `susp_i` high. The 3 edges are 2 synchronizer stages plus 1 output register.
- R3: `ohold_o` rises `HOLD_DLY` cycles after `wprot_o` rises.
- R4: `indis_o` rises `DIS_DLY` cycles after `ohold_o` rises.
- R5: With `filt_en_i` high, every entry event is delayed by `FILT_LEN` cycles. If `susp_i` falls before the window has passed, no output changes.
- R6: Once `susp_i` has fallen in the sleep state, `awake_o` rises and `indis_o` falls in the same cycle, 3 + `WAKE_DLY` edges after the fall is first sampled.
- R7: `wprot_o` falls exactly `wp_cnt_i` cycles after `awake_o` rises. The count is an unsigned value from 1 to 512.
- R8: `ohold_o` falls exactly `oh_cnt_i` cycles after `awake_o` rises. This count is independent of `wp_cnt_i` and also ranges from 1 to 512.
- R9: If `susp_i` rises again during the wake-up delay, `awake_o` never rises and all three protections stay asserted.
- R10: If `susp_i` rises again after `awake_o` has risen but before both releases are done, `awake_o` falls 3 cycles later with `wprot_o` held high. `indis_o` is then reasserted `HOLD_DLY` + `DIS_DLY` cycles after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| susp_i | input | 1 | Sleep request, asynchronous |
| filt_en_i | input | 1 | Enables the request glitch filter |
| wp_cnt_i | input | REL_W | Cycles from wake until the write lock is released (1..REL_MAX) |
| oh_cnt_i | input | REL_W | Cycles from wake until the pin freeze is released (1..REL_MAX) |
| awake_o | output | 1 | High while the device is awake |
| wprot_o | output | 1 | Write lock on all clocked storage |
| ohold_o | output | 1 | Holds the pins at their sleep behaviour |
| indis_o | output | 1 | Disables inputs and interconnect |

## Verification
The bench drives both release counts at 1 and at 512, in both orders. A counter that is off by one shifts the release edge by a cycle, and a swapped or shared counter releases the wrong output, so the bench catches both. It sends a filtered pulse shorter than the window. A filter that only delays entry, and does not restart it, would then put the device to sleep. The bench also raises the request again during the wake-up delay and again during the release phase. A design that ignores the new request would raise `awake_o` or drop the write lock while sleep is being requested.

// File: rtl/slumber_pkg.sv
package slumber_pkg;

    // Phases of the sleep/wake sequence
    typedef enum logic [2:0] {
        PH_RUN,     // fully awake
        PH_QUAL,    // request being qualified by the glitch filter
        PH_LOCK,    // write lock on, waiting to freeze the pins
        PH_FREEZE,  // pins frozen, waiting to cut off the inputs
        PH_SLEEP,   // fully asleep
        PH_RISE,    // wake-up delay running
        PH_THAW     // awake, release counters running
    } phase_e;

endpackage

// File: rtl/slumber_sync.sv
module slumber_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) chain_q <= '0;
                else         chain_q <= d_i;
            end
        end else begin : g_many
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) chain_q <= '0;
                else         chain_q <= {chain_q[STAGES-2:0], d_i};
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/slumber_core.sv
module slumber_core
    import slumber_pkg::*;
#(
    parameter int FILT_LEN = 8,
    parameter int HOLD_DLY = 2,
    parameter int DIS_DLY  = 6,
    parameter int WAKE_DLY = 10,
    parameter int REL_MAX  = 512,
    localparam int REL_W   = $clog2(REL_MAX + 1)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             req_i,
    input  logic             filt_en_i,
    input  logic [REL_W-1:0] wp_cnt_i,
    input  logic [REL_W-1:0] oh_cnt_i,
    output logic             awake_o,
    output logic             wprot_o,
    output logic             ohold_o,
    output logic             indis_o
);
    localparam int MAX_AB  = (FILT_LEN > HOLD_DLY) ? FILT_LEN : HOLD_DLY;
    localparam int MAX_CD  = (DIS_DLY > WAKE_DLY) ? DIS_DLY : WAKE_DLY;
    localparam int STG_MAX = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
    localparam int STG_W   = $clog2(STG_MAX + 1);

    typedef struct packed {
        phase_e           ph;
        logic [STG_W-1:0] stg;
        logic [REL_W-1:0] wp_left;
        logic [REL_W-1:0] oh_left;
        logic             awake;
        logic             wprot;
        logic             ohold;
        logic             indis;
    } seq_t;

    seq_t r_q, r_d;

    logic [REL_W-1:0] wp_eff, oh_eff;

    // A zero count is treated as one
    assign wp_eff = (wp_cnt_i == '0) ? REL_W'(1) : wp_cnt_i;
    assign oh_eff = (oh_cnt_i == '0) ? REL_W'(1) : oh_cnt_i;

    always_comb begin
        r_d = r_q;
        case (r_q.ph)
            PH_RUN: begin
                if (req_i) begin
                    if (filt_en_i) begin
                        r_d.ph  = PH_QUAL;
                        r_d.stg = STG_W'(FILT_LEN - 1);
                    end else begin
                        r_d.ph    = PH_LOCK;
                        r_d.stg   = STG_W'(HOLD_DLY - 1);
                        r_d.awake = 1'b0;
                        r_d.wprot = 1'b1;
                    end
                end
            end
            PH_QUAL: begin
                if (!req_i) begin
                    r_d.ph = PH_RUN;
                end else if (r_q.stg == '0) begin
                    r_d.ph    = PH_LOCK;
                    r_d.stg   = STG_W'(HOLD_DLY - 1);
                    r_d.awake = 1'b0;
                    r_d.wprot = 1'b1;
                end else begin
                    r_d.stg = r_q.stg - 1'b1;
                end
            end
            PH_LOCK: begin
                if (r_q.stg == '0) begin
                    r_d.ph    = PH_FREEZE;
                    r_d.stg   = STG_W'(DIS_DLY - 1);
                    r_d.ohold = 1'b1;
                end else begin
                    r_d.stg = r_q.stg - 1'b1;
                end
            end
            PH_FREEZE: begin
                if (r_q.stg == '0) begin
                    r_d.ph    = PH_SLEEP;
                    r_d.indis = 1'b1;
                end else begin
                    r_d.stg = r_q.stg - 1'b1;
                end
            end
            PH_SLEEP: begin
                if (!req_i) begin
                    r_d.ph  = PH_RISE;
                    r_d.stg = STG_W'(WAKE_DLY - 1);
                end
            end
            PH_RISE: begin
                if (req_i) begin
                    // abort the exit: protections stay on, entry restarts at the lock
                    r_d.ph  = PH_LOCK;
                    r_d.stg = STG_W'(HOLD_DLY - 1);
                end else if (r_q.stg == '0) begin
                    r_d.ph      = PH_THAW;
                    r_d.awake   = 1'b1;
                    r_d.indis   = 1'b0;
                    r_d.wp_left = wp_eff;
                    r_d.oh_left = oh_eff;
                end else begin
                    r_d.stg = r_q.stg - 1'b1;
                end
            end
            PH_THAW: begin
                if (req_i) begin
                    r_d.ph    = PH_LOCK;
                    r_d.stg   = STG_W'(HOLD_DLY - 1);
                    r_d.awake = 1'b0;
                    r_d.wprot = 1'b1;
                end else begin
                    if (r_q.wp_left != '0) begin
                        r_d.wp_left = r_q.wp_left - 1'b1;
                        if (r_q.wp_left == REL_W'(1)) r_d.wprot = 1'b0;
                    end
                    if (r_q.oh_left != '0) begin
                        r_d.oh_left = r_q.oh_left - 1'b1;
                        if (r_q.oh_left == REL_W'(1)) r_d.ohold = 1'b0;
                    end
                    if (r_q.wp_left <= REL_W'(1) && r_q.oh_left <= REL_W'(1))
                        r_d.ph = PH_RUN;
                end
            end
            default: r_d = r_q;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q <= '{ph: PH_RUN, stg: '0, wp_left: '0, oh_left: '0,
                     awake: 1'b1, wprot: 1'b0, ohold: 1'b0, indis: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign awake_o = r_q.awake;
    assign wprot_o = r_q.wprot;
    assign ohold_o = r_q.ohold;
    assign indis_o = r_q.indis;
endmodule

// File: rtl/slumber_seq.sv
module slumber_seq #(
    parameter int FILT_LEN = 8,
    parameter int HOLD_DLY = 2,
    parameter int DIS_DLY  = 6,
    parameter int WAKE_DLY = 10,
    parameter int REL_MAX  = 512,
    parameter int SYNC_LEN = 2,
    localparam int REL_W   = $clog2(REL_MAX + 1)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             susp_i,
    input  logic             filt_en_i,
    input  logic [REL_W-1:0] wp_cnt_i,
    input  logic [REL_W-1:0] oh_cnt_i,
    output logic             awake_o,
    output logic             wprot_o,
    output logic             ohold_o,
    output logic             indis_o
);
    logic req_s;

    slumber_sync #(.STAGES(SYNC_LEN)) u_sync (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .d_i   (susp_i),
        .q_o   (req_s)
    );

    slumber_core #(
        .FILT_LEN(FILT_LEN),
        .HOLD_DLY(HOLD_DLY),
        .DIS_DLY (DIS_DLY),
        .WAKE_DLY(WAKE_DLY),
        .REL_MAX (REL_MAX)
    ) u_core (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .req_i    (req_s),
        .filt_en_i(filt_en_i),
        .wp_cnt_i (wp_cnt_i),
        .oh_cnt_i (oh_cnt_i),
        .awake_o  (awake_o),
        .wprot_o  (wprot_o),
        .ohold_o  (ohold_o),
        .indis_o  (indis_o)
    );
endmodule

// File: rtl/slumber_seq_chk.sv
module slumber_seq_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic awake_o,
    input logic wprot_o,
    input logic ohold_o,
    input logic indis_o
);
    AST_LOCK_WITH_SLEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(awake_o) |-> wprot_o);                          // R2
    AST_FREEZE_AFTER_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(ohold_o) |-> (wprot_o && !awake_o));            // R3
    AST_CUT_AFTER_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(indis_o) |-> ohold_o);                          // R4
    AST_WAKE_REENABLES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(awake_o) |-> $fell(indis_o));                   // R6
    AST_ASLEEP_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !awake_o |-> wprot_o);                                // R10
endmodule

bind slumber_seq slumber_seq_chk u_chk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .awake_o(awake_o),
    .wprot_o(wprot_o),
    .ohold_o(ohold_o),
    .indis_o(indis_o)
);

// File: tb/sim_slumber_seq.sv
module sim_slumber_seq;
    localparam int F  = 8;
    localparam int HD = 2;
    localparam int DD = 6;
    localparam int WD = 10;
    localparam int RW = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic susp = 1'b0;
    logic filt = 1'b0;
    logic [RW-1:0] wpc = 10'd1;
    logic [RW-1:0] ohc = 10'd1;
    logic awake, wprot, ohold, indis;

    always #10 clk = ~clk;   // 50 MHz

    slumber_seq #(.FILT_LEN(F), .HOLD_DLY(HD), .DIS_DLY(DD), .WAKE_DLY(WD), .REL_MAX(512)) u0 (
        .clk_i(clk), .rst_ni(rst_n), .susp_i(susp), .filt_en_i(filt),
        .wp_cnt_i(wpc), .oh_cnt_i(ohc),
        .awake_o(awake), .wprot_o(wprot), .ohold_o(ohold), .indis_o(indis)
    );

    typedef struct {
        int    cyc;
        int    sig;   // 0 awake, 1 wprot, 2 ohold, 3 indis
        bit    val;
        string tag;
    } ev_t;

    ev_t exp_q[$];
    int  cyc = 0;
    int  n_vec = 0;
    int  n_bad = 0;
    bit  armed = 1'b0;
    bit  done = 1'b0;
    logic [3:0] prev;

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: every output edge must match the head of the expected queue
    always @(negedge clk) begin
        logic [3:0] cur;
        cur = {indis, ohold, wprot, awake};
        if (armed) begin
            for (int i = 0; i < 4; i++) begin
                if (cur[i] !== prev[i]) begin
                    n_vec++;
                    if (exp_q.size() == 0) begin
                        n_bad++;
                        $display("FAIL unexpected edge: sig %0d -> %0b at cycle %0d, expected none", i, cur[i], cyc);
                    end else begin
                        ev_t e;
                        e = exp_q.pop_front();
                        if (e.cyc != cyc || e.sig != i || e.val != cur[i]) begin
                            n_bad++;
                            $display("FAIL %s: sig %0d -> %0b at cycle %0d, expected sig %0d -> %0b at cycle %0d",
                                     e.tag, i, cur[i], cyc, e.sig, e.val, e.cyc);
                        end
                    end
                end
            end
        end
        prev = cur;
    end

    task automatic push(input int c, input int s, input bit v, input string t);
        ev_t e;
        e.cyc = c; e.sig = s; e.val = v; e.tag = t;
        exp_q.push_back(e);
    endtask

    task automatic check(input bit ok, input string t, input logic [3:0] act, input logic [3:0] expv);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: outputs {dis,hold,prot,awake} = %b, expected %b", t, act, expv);
        end
    endtask

    task automatic settle();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (5) @(negedge clk);
    endtask

    // called at a negedge
    task automatic enter(input bit filtered);
        int b;
        b = cyc + 3 + (filtered ? F : 0);
        susp = 1'b1;
        push(b, 0, 1'b0, filtered ? "R5" : "R2");
        push(b, 1, 1'b1, filtered ? "R5" : "R2");
        push(b + HD, 2, 1'b1, "R3");
        push(b + HD + DD, 3, 1'b1, "R4");
    endtask

    task automatic leave(input int np, input int nh, input bit rel);
        int a;
        a = cyc + 3 + WD;
        wpc = RW'(np);
        ohc = RW'(nh);
        susp = 1'b0;
        push(a, 0, 1'b1, "R6");
        push(a, 3, 1'b0, "R6");
        if (rel) begin
            if (np <= nh) begin
                push(a + np, 1, 1'b0, "R7");
                push(a + nh, 2, 1'b0, "R8");
            end else begin
                push(a + nh, 2, 1'b0, "R8");
                push(a + np, 1, 1'b0, "R7");
            end
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check({indis, ohold, wprot, awake} === 4'b0001, "R1 reset", {indis, ohold, wprot, awake}, 4'b0001);
        prev = {indis, ohold, wprot, awake};
        armed = 1'b1;

        // unfiltered entry, exits with release counts 1/512 and 512/1
        enter(1'b0); settle();
        leave(1, 512, 1'b1); settle();
        enter(1'b0); settle();
        leave(512, 1, 1'b1); settle();

        // filter rejects a short pulse (R5)
        filt = 1'b1;
        susp = 1'b1;
        repeat (4) @(negedge clk);
        susp = 1'b0;
        repeat (30) @(negedge clk);
        check({indis, ohold, wprot, awake} === 4'b0001, "R5 short pulse", {indis, ohold, wprot, awake}, 4'b0001);

        // filtered entry, equal release counts
        enter(1'b1); settle();
        leave(3, 3, 1'b1); settle();
        filt = 1'b0;

        // abort during the wake-up delay (R9)
        enter(1'b0); settle();
        susp = 1'b0;
        repeat (4) @(negedge clk);
        susp = 1'b1;
        repeat (40) @(negedge clk);
        check({indis, ohold, wprot, awake} === 4'b1110, "R9 wake abort", {indis, ohold, wprot, awake}, 4'b1110);
        leave(2, 5, 1'b1); settle();

        // abort during the release phase (R10)
        enter(1'b0); settle();
        leave(512, 512, 1'b0);
        while (exp_q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
        begin
            int t2;
            t2 = cyc;
            susp = 1'b1;
            push(t2 + 3, 0, 1'b0, "R10");
            push(t2 + 3 + HD + DD, 3, 1'b1, "R10");
        end
        settle();
        check({indis, ohold, wprot, awake} === 4'b1110, "R10 release abort", {indis, ohold, wprot, awake}, 4'b1110);
        leave(1, 1, 1'b1); settle();

        repeat (20) @(negedge clk);
        check(exp_q.size() == 0, "R1-end queue", 4'(exp_q.size()), 4'b0000);
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule